// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with Dedicated HI/LO Result Pair

This block performs 32-bit integer multiplication and division, signed or unsigned, one bit per clock. A host core issues a command with two operands on a single-cycle start pulse. The unit then stays busy while it iterates, and raises done for one cycle when the answer is ready. Results never go to a general register file. They land in two dedicated result registers: a high word and a low word.

After a multiply, the pair holds the full 64-bit product, with the upper half in the high word and the lower half in the low word. After a divide, the low word holds the quotient and the high word holds the remainder. The host copies either word into its own registers by reading the two always-visible result outputs. It can also load either word directly through a write port while the unit is idle.

Signed commands work on magnitudes and correct the signs in the final cycle. A zero divisor gives defined results and a one-cycle flag.

Top module: `muldiv_unit`

## Requirements
- R1: Command 2'b00 (unsigned multiply) leaves the low 32 bits of the unsigned 64-bit product on lo_out and the high 32 bits on hi_out.
- R2: Command 2'b01 (signed multiply) leaves the two's-complement 64-bit product of the signed operands split the same way: low half on lo_out, high half on hi_out.
- R3: Command 2'b10 (unsigned divide) leaves the quotient op_a/op_b on lo_out and the remainder on hi_out.
- R4: Command 2'b11 (signed divide) truncates the quotient toward zero and gives the remainder the sign of the dividend. The most negative dividend divided by -1 yields quotient 32'h8000_0000 and remainder 0.
- R5: A divide with op_b equal to zero, signed or unsigned, yields lo_out = 32'hFFFF_FFFF and hi_out = op_a. div_zero is high for exactly the done cycle; div_zero is never high outside a done cycle.
- R6: A start accepted while idle makes busy high from the next cycle. done is high for exactly one cycle, 33 rising edges after the edge that sampled start. busy is low whenever done is high.
- R7: A start pulse while busy is high is ignored: that operation produces no extra done and does not alter the running result.
- R8: While busy is high, hi_out and lo_out keep their previous values. They change only in the cycle in which done rises.
- R9: With busy low, wr_hi or wr_lo loads wr_data into the high or low word, visible after the next edge. While busy is high, these writes have no effect.
- R10: After reset, hi_out, lo_out, busy, done and div_zero are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (honoured only when idle) |
| cmd | input | 2 | bit 1: divide; bit 0: signed |
| op_a | input | 32 | Multiplicand or dividend |
| op_b | input | 32 | Multiplier or divisor |
| wr_hi | input | 1 | Load high word from wr_data (idle only) |
| wr_lo | input | 1 | Load low word from wr_data (idle only) |
| wr_data | input | 32 | Data for direct loads |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| div_zero | output | 1 | Divisor was zero, valid with done |
| hi_out | output | 32 | High result word (product high or remainder) |
| lo_out | output | 32 | Low result word (product low or quotient) |

## Verification
The hardest situation to reach is traffic that arrives while an operation is running. This covers a second start, direct writes, and reads of the old result, all in the middle of an iteration, with the unit required to ignore the first two and keep the third stable. The bench starts a multiply, waits a few cycles into the iteration, checks that both result words still hold the prior values, and then fires a start with different operands together with both write strobes. The scoreboard then expects exactly one completion, carrying the first multiply's product. Signed corner operands (most negative value, -1, zero divisor with a negative dividend) are issued directly to exercise the sign-correction and zero-divisor paths.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic [1:0] {
    CMD_MULU = 2'b00,
    CMD_MULS = 2'b01,
    CMD_DIVU = 2'b10,
    CMD_DIVS = 2'b11
  } md_cmd_e;

  // Sign-correction plan captured at start, applied in the final cycle
  typedef struct packed {
    logic is_div;
    logic neg_prod;
    logic neg_quo;
    logic neg_rem;
    logic div_zero;
  } md_fix_t;

endpackage

// File: rtl/muldiv_prep.sv
module muldiv_prep
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [1:0]   cmd,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] mag_a,
  output logic [W-1:0] mag_b,
  output md_fix_t      fix
);
  localparam int NOPS = 2;

  logic [W-1:0] ops  [NOPS];
  logic [W-1:0] mags [NOPS];
  logic         negs [NOPS];
  logic         sgn;

  assign sgn    = cmd[0];
  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar i = 0; i < NOPS; i++) begin : g_abs
    assign negs[i] = sgn & ops[i][W-1];
    assign mags[i] = negs[i] ? (~ops[i] + 1'b1) : ops[i];
  end

  assign mag_a = mags[0];
  assign mag_b = mags[1];

  always_comb begin
    fix.is_div   = cmd[1];
    fix.div_zero = cmd[1] && (op_b == '0);
    fix.neg_prod = negs[0] ^ negs[1];
    fix.neg_quo  = (negs[0] ^ negs[1]) && !fix.div_zero;
    fix.neg_rem  = negs[0];
  end

endmodule

// File: rtl/muldiv_step.sv
module muldiv_step #(
  parameter int W = 32
) (
  input  logic         is_div,
  input  logic [W-1:0] hi_in,
  input  logic [W-1:0] lo_in,
  input  logic [W-1:0] opd,
  output logic [W-1:0] hi_nxt,
  output logic [W-1:0] lo_nxt
);
  logic [W:0] sum;
  logic [W:0] trial;

  always_comb begin
    sum   = {1'b0, hi_in} + (lo_in[0] ? {1'b0, opd} : '0);
    trial = {hi_in, lo_in[W-1]} - {1'b0, opd};
    if (!is_div) begin
      // shift-and-add: product accumulates in {hi,lo}, multiplier drains from lo
      hi_nxt = sum[W:1];
      lo_nxt = {sum[0], lo_in[W-1:1]};
    end else if (!trial[W]) begin
      hi_nxt = trial[W-1:0];
      lo_nxt = {lo_in[W-2:0], 1'b1};
    end else begin
      // restore: keep shifted partial remainder
      hi_nxt = {hi_in[W-2:0], lo_in[W-1]};
      lo_nxt = {lo_in[W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/muldiv_fix.sv
module muldiv_fix
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  md_fix_t      fix,
  input  logic [W-1:0] hi_in,
  input  logic [W-1:0] lo_in,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo
);
  localparam int DW = 2 * W;

  logic [DW-1:0] prod;

  always_comb begin
    prod = {hi_in, lo_in};
    if (fix.neg_prod) prod = ~prod + 1'b1;
    if (fix.is_div) begin
      res_lo = fix.neg_quo ? (~lo_in + 1'b1) : lo_in;
      res_hi = fix.neg_rem ? (~hi_in + 1'b1) : hi_in;
    end else begin
      res_lo = prod[W-1:0];
      res_hi = prod[DW-1:W];
    end
  end

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [1:0]   cmd,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         wr_hi,
  input  logic         wr_lo,
  input  logic [W-1:0] wr_data,
  output logic         busy,
  output logic         done,
  output logic         div_zero,
  output logic [W-1:0] hi_out,
  output logic [W-1:0] lo_out
);
  localparam int CNTW = $clog2(W + 1);

  logic [W-1:0]    mag_a, mag_b;
  md_fix_t         fix_d, fix_q;
  logic [W-1:0]    work_hi, work_lo, opd_q;
  logic [W-1:0]    step_hi, step_lo;
  logic [W-1:0]    res_hi, res_lo;
  logic [CNTW-1:0] cnt;

  muldiv_prep #(.W(W)) u_prep (
    .cmd(cmd), .op_a(op_a), .op_b(op_b),
    .mag_a(mag_a), .mag_b(mag_b), .fix(fix_d)
  );

  muldiv_step #(.W(W)) u_step (
    .is_div(fix_q.is_div), .hi_in(work_hi), .lo_in(work_lo), .opd(opd_q),
    .hi_nxt(step_hi), .lo_nxt(step_lo)
  );

  muldiv_fix #(.W(W)) u_fix (
    .fix(fix_q), .hi_in(work_hi), .lo_in(work_lo),
    .res_hi(res_hi), .res_lo(res_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      div_zero <= 1'b0;
      cnt      <= '0;
      work_hi  <= '0;
      work_lo  <= '0;
      opd_q    <= '0;
      fix_q    <= '0;
      hi_out   <= '0;
      lo_out   <= '0;
    end else begin
      done     <= 1'b0;
      div_zero <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          cnt     <= CNTW'(W);
          work_hi <= '0;
          work_lo <= mag_a;
          opd_q   <= mag_b;
          fix_q   <= fix_d;
        end
        if (wr_hi) hi_out <= wr_data;
        if (wr_lo) lo_out <= wr_data;
      end else if (cnt != '0) begin
        work_hi <= step_hi;
        work_lo <= step_lo;
        cnt     <= cnt - 1'b1;
      end else begin
        hi_out   <= res_hi;
        lo_out   <= res_lo;
        done     <= 1'b1;
        div_zero <= fix_q.div_zero;
        busy     <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         wr_hi,
  input logic         wr_lo,
  input logic [W-1:0] wr_data,
  input logic         busy,
  input logic         done,
  input logic         div_zero,
  input logic [W-1:0] hi_out,
  input logic [W-1:0] lo_out
);

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R6

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy); // R6

  AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy)); // R7

  AST_DZ_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    div_zero |-> done); // R5

  AST_HI_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |=> (done || $stable(hi_out))); // R8

  AST_LO_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |=> (done || $stable(lo_out))); // R8

  AST_WRITE_HI_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && wr_hi) |=> (hi_out == $past(wr_data))); // R9

  AST_WRITE_LO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && wr_lo) |=> (lo_out == $past(wr_data))); // R9

endmodule

bind muldiv_unit muldiv_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .wr_hi(wr_hi), .wr_lo(wr_lo),
  .wr_data(wr_data), .busy(busy), .done(done), .div_zero(div_zero),
  .hi_out(hi_out), .lo_out(lo_out)
);

// File: tb/sim_muldiv_unit.sv
module sim_muldiv_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int LAT = W + 2; // negedges from start drive to done visible

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [1:0]   cmd = 2'b00;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic         wr_hi = 1'b0, wr_lo = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         busy, done, div_zero;
  logic [W-1:0] hi_out, lo_out;

  int checks = 0;
  int errors = 0;
  int dones  = 0;

  typedef struct {
    logic [31:0] hi;
    logic [31:0] lo;
    logic        dz;
    string       tag;
  } exp_t;

  exp_t sbq[$];

  muldiv_unit #(.W(W)) u0 (
    .clk(clk), .rst(rst), .start(start), .cmd(cmd), .op_a(op_a), .op_b(op_b),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
    .busy(busy), .done(done), .div_zero(div_zero),
    .hi_out(hi_out), .lo_out(lo_out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [1:0] c, input logic [31:0] a,
                                 input logic [31:0] b, input string tag);
    exp_t e;
    logic [63:0] p;
    longint sa, sb, q, r;
    e.tag = tag;
    e.dz  = 1'b0;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (c)
      2'b00: begin p = {32'b0, a} * {32'b0, b}; e.hi = p[63:32]; e.lo = p[31:0]; end
      2'b01: begin p = 64'(sa * sb); e.hi = p[63:32]; e.lo = p[31:0]; end
      default: begin
        if (b == 0) begin
          e.lo = 32'hFFFF_FFFF; e.hi = a; e.dz = 1'b1;
        end else if (c == 2'b10) begin
          e.lo = a / b; e.hi = a % b;
        end else begin
          q = sa / sb; r = sa % sb;
          e.lo = q[31:0]; e.hi = r[31:0];
        end
      end
    endcase
    return e;
  endfunction

  // Monitor: pop and compare on every completion
  always @(negedge clk) begin
    if (!rst && done) begin
      exp_t e;
      dones++;
      if (sbq.size() == 0) begin
        check(1'b0, "R7", "unexpected done", 64'(done), 64'(0));
      end else begin
        e = sbq.pop_front();
        check(lo_out == e.lo, e.tag, "lo_out", 64'(lo_out), 64'(e.lo));
        check(hi_out == e.hi, e.tag, "hi_out", 64'(hi_out), 64'(e.hi));
        check(div_zero == e.dz, e.dz ? "R5" : e.tag, "div_zero", 64'(div_zero), 64'(e.dz));
      end
    end
  end

  task automatic run_op(input logic [1:0] c, input logic [31:0] a,
                        input logic [31:0] b, input string tag);
    int n;
    @(negedge clk);
    start = 1'b1; cmd = c; op_a = a; op_b = b;
    sbq.push_back(model(c, a, b, tag));
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R6", "busy after start", 64'(busy), 64'(1));
    n = 1;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(n == LAT, "R6", "latency", 64'(n), 64'(LAT));
    check(busy == 1'b0, "R6", "busy with done", 64'(busy), 64'(0));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    check(1'b0, "R6", "watchdog expired", 64'(0), 64'(1));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(hi_out == 0 && lo_out == 0, "R10", "hi/lo after reset", {hi_out, lo_out}, 64'(0));
    check(busy == 0, "R10", "busy after reset", 64'(busy), 64'(0));
    check(done == 0 && div_zero == 0, "R10", "done/dz after reset", {done, div_zero}, 64'(0));

    // Unsigned multiply
    run_op(2'b00, 32'd12345, 32'd6789, "R1");
    run_op(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1");
    run_op(2'b00, 32'h8000_0000, 32'd2, "R1");
    // Signed multiply
    run_op(2'b01, -32'sd7, 32'd3, "R2");
    run_op(2'b01, -32'sd1, -32'sd1, "R2");
    run_op(2'b01, 32'h8000_0000, 32'h7FFF_FFFF, "R2");
    // Unsigned divide
    run_op(2'b10, 32'd1000, 32'd7, "R3");
    run_op(2'b10, 32'hFFFF_FFFF, 32'd16, "R3");
    run_op(2'b10, 32'd5, 32'd9, "R3");
    // Signed divide
    run_op(2'b11, -32'sd7, 32'd2, "R4");
    run_op(2'b11, 32'd7, -32'sd2, "R4");
    run_op(2'b11, -32'sd7, -32'sd2, "R4");
    run_op(2'b11, 32'h8000_0000, 32'hFFFF_FFFF, "R4");
    // Divide by zero
    run_op(2'b10, 32'd77, 32'd0, "R5");
    run_op(2'b11, -32'sd77, 32'd0, "R5");
    @(negedge clk);
    check(div_zero == 0, "R5", "flag one cycle", 64'(div_zero), 64'(0));

    // Direct loads while idle
    wr_hi = 1'b1; wr_data = 32'hA5A5_0001;
    @(negedge clk);
    wr_hi = 1'b0;
    check(hi_out == 32'hA5A5_0001, "R9", "idle hi write", 64'(hi_out), 64'(32'hA5A5_0001));
    wr_lo = 1'b1; wr_data = 32'h5A5A_0002;
    @(negedge clk);
    wr_lo = 1'b0;
    check(lo_out == 32'h5A5A_0002, "R9", "idle lo write", 64'(lo_out), 64'(32'h5A5A_0002));
    check(hi_out == 32'hA5A5_0001, "R9", "hi untouched by lo write", 64'(hi_out), 64'(32'hA5A5_0001));

    // Traffic during a running operation
    start = 1'b1; cmd = 2'b00; op_a = 32'd3; op_b = 32'd5;
    sbq.push_back(model(2'b00, 32'd3, 32'd5, "R7"));
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    check(hi_out == 32'hA5A5_0001, "R8", "hi held while busy", 64'(hi_out), 64'(32'hA5A5_0001));
    check(lo_out == 32'h5A5A_0002, "R8", "lo held while busy", 64'(lo_out), 64'(32'h5A5A_0002));
    start = 1'b1; cmd = 2'b11; op_a = 32'd100; op_b = 32'd0;
    wr_hi = 1'b1; wr_lo = 1'b1; wr_data = 32'hDEAD_BEEF;
    @(negedge clk);
    start = 1'b0; wr_hi = 1'b0; wr_lo = 1'b0;
    check(hi_out == 32'hA5A5_0001, "R9", "busy hi write ignored", 64'(hi_out), 64'(32'hA5A5_0001));
    check(lo_out == 32'h5A5A_0002, "R9", "busy lo write ignored", 64'(lo_out), 64'(32'h5A5A_0002));
    for (int i = 0; i < 200 && !done; i++) @(negedge clk);
    repeat (LAT + 5) @(negedge clk);
    check(busy == 0, "R7", "no second operation", 64'(busy), 64'(0));
    check(dones == 16, "R7", "completion count", 64'(dones), 64'(16));
    check(sbq.size() == 0, "R7", "scoreboard drained", 64'(sbq.size()), 64'(0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule